// File: doc/BRIEF.md
# Overlapping Serial Pattern Recognizer

This block watches one serial bit per rising clock edge and flags, on a single output, that a fixed bit pattern has just arrived. A build-time parameter chooses which pattern is searched for: the three-bit pattern 1,0,1 or the four-bit pattern 1,1,0,1. Each pattern has its own small state machine. The state records the longest leading part of the pattern that the most recent bits match, and a terminal state marks a complete hit.

The match flag is a Moore output. It is decoded from the current state only, so it goes high in the clock period that follows the edge on which the last pattern bit was taken. Hits may overlap. Trailing bits of one hit count toward the next: for 1,0,1 the closing 1 can open a new hit, and for 1,1,0,1 the closing 1 can be the first of the pair 1,1. States use the fewest possible bits, which is two for the short pattern and three for the long one. A synchronous reset returns the machine to its empty state.

Top module: `serial_pattern_recognizer`

## Requirements
- R1: When `rst` is 1 at a rising edge, `matchOut` is 0 during the following clock period, whatever `serIn` was at that edge.
- R2: With `PATTERN_SEL`=0, `matchOut` is 1 during a clock period exactly when the last three bits sampled since reset were, oldest first, 1,0,1.
- R3: With `PATTERN_SEL`=1, `matchOut` is 1 during a clock period exactly when the last four bits sampled since reset were, oldest first, 1,1,0,1.
- R4: Overlap for 1,0,1. The stream 0,1,0,1,0,1,1,1,0,1,0,1,0,1,0 applied in periods 1 to 15 after reset gives `matchOut`=1 in periods 5, 7, 11, 13 and 15, and 0 in all other periods.
- R5: Overlap for 1,1,0,1. The stream 0,1,1,0,1,0,1,1,0,1,1,0,1,1,0 applied in periods 1 to 15 after reset gives `matchOut`=1 in periods 6, 11 and 14, and 0 in all other periods.
- R6: `matchOut` changes only just after a rising edge. Moving `serIn` inside a clock period leaves `matchOut` unchanged for the rest of that period.
- R7: Reset discards a partly received pattern. After 1,0 then a reset edge, a single following 1 produces no hit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; `serIn` is sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| serIn | input | 1 | Serial data bit |
| matchOut | output | 1 | High for the period after a complete pattern was received |

## Verification
Every result is due one edge after the stimulus that causes it. The bit taken at a rising edge, or a reset taken at that edge, shows on `matchOut` for the whole following period. The bench drives a new bit at each falling edge. Before it drives that bit, it compares `matchOut` with a shift-register model of the bits accepted at earlier edges, so each comparison lands exactly one register stage after its cause. For the check that the output ignores input changes inside a period, the bench wiggles `serIn` between a falling edge and the next rising edge and samples again before that rising edge.

// File: rtl/spr_pkg.sv
package spr_pkg;

  // Strobes the control FSM hands to the output stage.
  typedef struct packed {
    logic atMatch;   // FSM sits in its terminal (full pattern) state
    logic atIdle;    // FSM holds no pattern prefix at all
  } ctrlStrobes_t;

  // Pattern selector encodings
  localparam int unsigned SEL_101  = 0;
  localparam int unsigned SEL_1101 = 1;

endpackage

// File: rtl/spr_ctrl.sv
module spr_ctrl
  import spr_pkg::*;
#(
  parameter int unsigned PATTERN_SEL = SEL_101,
  parameter int unsigned PAT_LEN     = 3,
  parameter int unsigned STATE_W     = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         serIn,
  output ctrlStrobes_t strobes
);

  // State code = length of the pattern prefix currently matched.
  localparam logic [STATE_W-1:0] S_IDLE = STATE_W'(0);
  localparam logic [STATE_W-1:0] S_P1   = STATE_W'(1);
  localparam logic [STATE_W-1:0] S_P2   = STATE_W'(2);
  localparam logic [STATE_W-1:0] S_HIT  = STATE_W'(PAT_LEN);

  logic [STATE_W-1:0] curState;
  logic [STATE_W-1:0] nxtState;

  generate
    if (PATTERN_SEL == SEL_101) begin : g101
      // prefixes: P1 = "1", P2 = "10", HIT = "101"
      always_comb begin
        case (curState)
          S_IDLE:  nxtState = serIn ? S_P1  : S_IDLE;
          S_P1:    nxtState = serIn ? S_P1  : S_P2;
          S_P2:    nxtState = serIn ? S_HIT : S_IDLE;
          S_HIT:   nxtState = serIn ? S_P1  : S_P2;
          default: nxtState = S_IDLE;
        endcase
      end

      // R2: completing 1,0,1 reaches the hit state
      p_hit_after_prefix_r2: assert property (@(posedge clk) disable iff (rst)
        (curState == S_P2 && serIn) |=> strobes.atMatch);

      // R4: hit followed by 0,1 is another hit (trailing 1 reused)
      p_overlap_short_r4: assert property (@(posedge clk) disable iff (rst)
        (strobes.atMatch && !serIn) ##1 serIn |=> strobes.atMatch);
    end else begin : g1101
      localparam logic [STATE_W-1:0] S_P3 = STATE_W'(3);
      // prefixes: P1 = "1", P2 = "11", P3 = "110", HIT = "1101"
      always_comb begin
        case (curState)
          S_IDLE:  nxtState = serIn ? S_P1  : S_IDLE;
          S_P1:    nxtState = serIn ? S_P2  : S_IDLE;
          S_P2:    nxtState = serIn ? S_P2  : S_P3;
          S_P3:    nxtState = serIn ? S_HIT : S_IDLE;
          S_HIT:   nxtState = serIn ? S_P2  : S_IDLE;
          default: nxtState = S_IDLE;
        endcase
      end

      // R3: completing 1,1,0,1 reaches the hit state
      p_hit_after_prefix_r3: assert property (@(posedge clk) disable iff (rst)
        (curState == S_P3 && serIn) |=> strobes.atMatch);

      // R5: hit followed by 1,0,1 is another hit (trailing 1 reused)
      p_overlap_long_r5: assert property (@(posedge clk) disable iff (rst)
        (strobes.atMatch && serIn) ##1 !serIn ##1 serIn |=> strobes.atMatch);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) curState <= S_IDLE;
    else     curState <= nxtState;
  end

  always_comb begin
    strobes.atMatch = (curState == S_HIT);
    strobes.atIdle  = (curState == S_IDLE);
  end

  // R1 / R7: a reset edge leaves no prefix behind
  p_reset_empties_r1: assert property (@(posedge clk)
    rst |=> (strobes.atIdle && !strobes.atMatch));

endmodule

// File: rtl/spr_datapath.sv
module spr_datapath
  import spr_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         serIn,
  input  ctrlStrobes_t strobes,
  output logic         matchOut
);

  // Moore output: decoded from state strobes only, never from serIn.
  always_comb matchOut = strobes.atMatch;

  // R2 / R3: every pattern ends in 1, so a rising flag needs a sampled 1
  p_last_bit_one_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(matchOut) |-> $past(serIn));

  // R6: the flag never stays up two periods in a row (no pattern allows it)
  p_single_period_r6: assert property (@(posedge clk) disable iff (rst)
    matchOut |=> !matchOut);

  // R1: idle and hit are exclusive
  p_strobe_excl_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobes.atMatch, strobes.atIdle}));

endmodule

// File: rtl/serial_pattern_recognizer.sv
module serial_pattern_recognizer
  import spr_pkg::*;
#(
  parameter int unsigned PATTERN_SEL = SEL_101
) (
  input  logic clk,
  input  logic rst,
  input  logic serIn,
  output logic matchOut
);

  localparam int unsigned PAT_LEN = (PATTERN_SEL == SEL_101) ? 3 : 4;
  localparam int unsigned STATE_W = $clog2(PAT_LEN + 1);

  ctrlStrobes_t strobes;

  spr_ctrl #(
    .PATTERN_SEL(PATTERN_SEL),
    .PAT_LEN    (PAT_LEN),
    .STATE_W    (STATE_W)
  ) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .serIn  (serIn),
    .strobes(strobes)
  );

  spr_datapath u_dp (
    .clk     (clk),
    .rst     (rst),
    .serIn   (serIn),
    .strobes (strobes),
    .matchOut(matchOut)
  );

endmodule

// File: tb/tb_serial_pattern_recognizer.sv
`timescale 1ns/1ps
module tb_serial_pattern_recognizer;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic x3  = 1'b0;
  logic x4  = 1'b0;
  logic y3;
  logic y4;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [2:0] h3 = '0;
  logic [3:0] h4 = '0;
  int n3 = 0;
  int n4 = 0;

  // tables for the two worked streams, periods 1..15
  logic [1:15] in3  = 15'b010101110101010;
  logic [1:15] exp3 = 15'b000010100010101;
  logic [1:15] in4  = 15'b011010110110110;
  logic [1:15] exp4 = 15'b000001000010010;

  always #4 clk = ~clk;  // 125 MHz

  serial_pattern_recognizer #(.PATTERN_SEL(0)) dut (
    .clk(clk), .rst(rst), .serIn(x3), .matchOut(y3));

  serial_pattern_recognizer #(.PATTERN_SEL(1)) dutLong (
    .clk(clk), .rst(rst), .serIn(x4), .matchOut(y4));

  function automatic logic model3(input logic [2:0] h, input int n);
    return (n >= 3) && (h == 3'b101);
  endfunction

  function automatic logic model4(input logic [3:0] h, input int n);
    return (n >= 4) && (h == 4'b1101);
  endfunction

  task automatic chk(input logic act, input logic expv, input string tag);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, expv, $time);
    end
  endtask

  // One clock period: check outputs at the falling edge, then drive.
  task automatic step(input logic b3, input logic b4, input logic r,
                      input logic wig, input logic useT,
                      input logic t3, input logic t4, input string tag);
    logic e3, e4;
    @(negedge clk);
    e3 = model3(h3, n3);
    e4 = model4(h4, n4);
    chk(y3, e3, {tag, " short"});
    chk(y4, e4, {tag, " long"});
    if (useT) begin
      chk(y3, t3, "R4 table");
      chk(y4, t4, "R5 table");
    end
    rst = r;
    if (wig) begin
      x3 = ~b3; x4 = ~b4; #1;
      chk(y3, e3, "R6 short wiggle");
      chk(y4, e4, "R6 long wiggle");
      x3 = b3; x4 = b4; #1;
      chk(y3, e3, "R6 short wiggle");
      chk(y4, e4, "R6 long wiggle");
    end
    x3 = b3; x4 = b4;
    @(posedge clk);
    #1;
    if (r) begin
      h3 = '0; h4 = '0; n3 = 0; n4 = 0;
    end else begin
      h3 = {h3[1:0], b3}; h4 = {h4[2:0], b4};
      n3++; n4++;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h5eed);

    // R1: reset state
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R1");

    // R4 / R5: worked streams against fixed tables
    for (int k = 1; k <= 15; k++)
      step(in3[k], in4[k], 1'b0, 1'b0, 1'b1, exp3[k], exp4[k], "R2/R3");
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R1");

    // R6: wiggle serIn inside hit periods and idle periods
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R6");
    step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R6");
    step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R6");
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R6");

    // R1: reset taken while in the hit state
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R1");

    // R5: 1101101 gives two overlapping hits on the long machine
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R5");

    // R7: partial prefix, then reset with a 1 on the line, then a 1
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R7");

    // R2 / R3: random streams with occasional resets
    for (int i = 0; i < 800; i++) begin
      logic rb;
      rb = (($urandom % 40) == 0);
      step(1'($urandom % 2), 1'($urandom % 2), rb, 1'b0, 1'b0,
           1'b0, 1'b0, "R2/R3");
    end
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2/R3");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule